// File: doc/BRIEF.md
# Switch Activity Logger with Byte-Stream Replay

This block watches an already debounced on/off switch and keeps a record of every change of its level. Each record holds the new switch direction and the time that passed since the previous change. That time is counted in ticks of a programmable divider, nominally 10 ms, and is clamped to a 7-bit value. The newest records are kept in a small circular log. When the log is full, a new record replaces the oldest one.

A second debounced input, the replay button, starts an upload of the whole log, oldest record first. Each record goes out as one byte on a valid/ready stream that feeds an external serial transmitter. The switch is still logged while an upload is running. A further press of the button during an upload is not acted on.

Top module: `sw_activity_log`

## Requirements
- R1: The recorded interval is the number of whole tick periods (TICK_CYCLES clock cycles each) in the edges that lie strictly between the edge that took the previous record and the edge that takes this one. With G such edges the value is floor(G / TICK_CYCLES).
- R2: An interval that would exceed 127 is recorded as 127.
- R3: Each record is one byte. Bit 7 holds the switch level after the change (1 = switched on, 0 = switched off). Bits 6:0 hold the interval.
- R4: Taking a record restarts the interval count at zero. The first record after reset measures from the first clock edge after reset is released. The switch level is taken as 0 at reset.
- R5: The log keeps the newest DEPTH records. When full, a new record overwrites the oldest. The number of stored records never exceeds DEPTH.
- R6: A rising edge of the replay button while idle sends exactly the stored records, from the oldest to the newest.
- R7: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data does not change.
- R8: During an upload, further rising edges of the button are ignored. A button held high starts only one upload.
- R9: Switch changes during an upload are still recorded. They appear in the next upload. The length of the running upload is fixed when it starts.
- R10: A button press with an empty log produces no output.
- R11: After reset, tx_valid is low and the log is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_level | input | 1 | Debounced switch level, synchronous to clk |
| dump_btn | input | 1 | Debounced replay button level, synchronous to clk |
| tx_data | output | 8 | Record byte offered to the transmitter |
| tx_valid | output | 1 | tx_data holds a record waiting to be taken |
| tx_ready | input | 1 | Transmitter accepts tx_data on this edge |

## Verification
The assertions assume that sw_level and dump_btn are clean, synchronous levels. They also assume that tx_ready may drop or rise on any cycle, whatever tx_valid is doing. The stimulus changes every input only at the falling clock edge. It toggles the switch as single clean transitions, with gaps of zero cycles up to well beyond saturation. It drives tx_ready in three patterns: always ready, ready one cycle in three, and held off for several cycles after the press. This exercises the hold rule and the injection of switch changes and button presses in the middle of an upload.

// File: rtl/swlog_pkg.sv
package swlog_pkg;
  localparam int IVAL_W = 7;
  localparam int REC_W  = IVAL_W + 1;
  localparam logic [IVAL_W-1:0] IVAL_MAX = '1;

  // record byte: direction on top, clamped interval below
  function automatic logic [REC_W-1:0] pack_rec(input logic dir,
                                                input logic [IVAL_W-1:0] iv);
    return {dir, iv};
  endfunction

  // next interval value: clear wins, then a saturating step on a tick
  function automatic logic [IVAL_W-1:0] ival_next(input logic [IVAL_W-1:0] cur,
                                                  input logic clr,
                                                  input logic tk);
    if (clr) return '0;
    if (tk && (cur != IVAL_MAX)) return cur + 1'b1;
    return cur;
  endfunction
endpackage

// File: rtl/swlog_tick.sv
module swlog_tick #(
  parameter int TICK_CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int TW = $clog2(TICK_CYCLES + 1);
  localparam logic [TW-1:0] LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/swlog_interval.sv
module swlog_interval
  import swlog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              tick,
  output logic [IVAL_W-1:0] ival
);
  logic [IVAL_W-1:0] ival_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ival_q <= '0;
    else        ival_q <= ival_next(ival_q, clear, tick);
  end

  assign ival = ival_q;
endmodule

// File: rtl/swlog_ring.sv
module swlog_ring
  import swlog_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REC_W-1:0] wr_data,
  input  logic [AW-1:0]    rd_idx,
  output logic [REC_W-1:0] rd_data,
  output logic [AW-1:0]    wr_ptr,
  output logic [CW-1:0]    count
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DEPTH-1:0][REC_W-1:0] slot_q;
  logic [AW-1:0]               wp_q;
  logic [CW-1:0]               cnt_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)                              slot_q[i] <= '0;
      else if (wr_en && (wp_q == AW'(i)))      slot_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
    end else if (wr_en) begin
      wp_q <= wp_q + 1'b1;
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_data = slot_q[rd_idx];
  assign wr_ptr  = wp_q;
  assign count   = cnt_q;
endmodule

// File: rtl/swlog_dump.sv
module swlog_dump
  import swlog_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             press,
  input  logic [CW-1:0]    log_count,
  input  logic [AW-1:0]    start_idx,
  input  logic [REC_W-1:0] rd_data,
  output logic [AW-1:0]    fetch_idx,
  output logic [REC_W-1:0] tx_data,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             busy,
  output logic             done
);
  logic             busy_q;
  logic [AW-1:0]    cur_q;
  logic [CW-1:0]    left_q;
  logic [REC_W-1:0] data_q;
  logic             start;

  assign start     = !busy_q && press && (log_count != '0);
  assign done      = busy_q && tx_ready && (left_q == CW'(1));
  assign fetch_idx = busy_q ? (cur_q + 1'b1) : start_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cur_q  <= start_idx;
      left_q <= log_count;
      data_q <= rd_data;
    end else if (busy_q && tx_ready) begin
      if (done) begin
        busy_q <= 1'b0;
      end else begin
        cur_q  <= cur_q + 1'b1;
        left_q <= left_q - 1'b1;
        data_q <= rd_data;
      end
    end
  end

  assign tx_data  = data_q;
  assign tx_valid = busy_q;
  assign busy     = busy_q;
endmodule

// File: rtl/sw_activity_log.sv
module sw_activity_log
  import swlog_pkg::*;
#(
  parameter int TICK_CYCLES = 250000,
  parameter int DEPTH       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_level,
  input  logic       dump_btn,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  // input edge detection
  logic sw_q, btn_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      btn_q <= 1'b0;
    end else begin
      sw_q  <= sw_level;
      btn_q <= dump_btn;
    end
  end

  // named internal events for the checker
  logic              op_evt;
  logic              press_evt;
  logic              tick_w;
  logic [IVAL_W-1:0] ival_w;
  logic [REC_W-1:0]  rec_w;
  logic [AW-1:0]     wr_ptr_w, start_idx_w, fetch_idx_w;
  logic [CW-1:0]     log_count_w;
  logic [REC_W-1:0]  rd_data_w;
  logic              busy_w, done_w;

  assign op_evt      = sw_level ^ sw_q;
  assign press_evt   = dump_btn & ~btn_q;
  assign rec_w       = pack_rec(sw_level, ival_w);
  assign start_idx_w = wr_ptr_w - AW'(log_count_w);

  swlog_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (op_evt),
    .tick  (tick_w)
  );

  swlog_interval u_ival (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (op_evt),
    .tick  (tick_w),
    .ival  (ival_w)
  );

  swlog_ring #(.DEPTH(DEPTH)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (op_evt),
    .wr_data (rec_w),
    .rd_idx  (fetch_idx_w),
    .rd_data (rd_data_w),
    .wr_ptr  (wr_ptr_w),
    .count   (log_count_w)
  );

  swlog_dump #(.DEPTH(DEPTH)) u_dump (
    .clk       (clk),
    .rst_n     (rst_n),
    .press     (press_evt),
    .log_count (log_count_w),
    .start_idx (start_idx_w),
    .rd_data   (rd_data_w),
    .fetch_idx (fetch_idx_w),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .busy      (busy_w),
    .done      (done_w)
  );
endmodule

// File: rtl/sw_activity_log_chk.sv
module sw_activity_log_chk
  import swlog_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              op_evt,
  input logic [IVAL_W-1:0] ival,
  input logic [CW-1:0]     log_count,
  input logic              busy,
  input logic              done
);
  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_evt |=> ival == '0);

  p_sat_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ival == IVAL_MAX) && !op_evt |=> ival == IVAL_MAX);

  p_count_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    log_count <= CW'(DEPTH));

  p_count_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_evt && (log_count == CW'(DEPTH)) |=> log_count == CW'(DEPTH));

  p_count_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_evt && (log_count < CW'(DEPTH)) |=> log_count == $past(log_count) + 1'b1);

  p_stay_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  p_empty_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (log_count == '0) |=> !tx_valid);
endmodule

bind sw_activity_log sw_activity_log_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .op_evt    (op_evt),
  .ival      (ival_w),
  .log_count (log_count_w),
  .busy      (busy_w),
  .done      (done_w)
);

// File: tb/sw_activity_log_bench.sv
module sw_activity_log_bench;
  localparam int T = 10;
  localparam int D = 16;
  localparam int NV = 10;
  // stimulus vectors: idle gap before a switch toggle, and the expected byte
  localparam int GAPS [NV] = '{35, 0, 9, 10, 1269, 1270, 2000, 57, 300, 19};
  localparam logic [7:0] EXPB [NV] =
    '{8'h83, 8'h00, 8'h80, 8'h01, 8'hFE, 8'h7F, 8'hFF, 8'h05, 8'h9E, 8'h01};

  logic clk = 1'b0, rst_n = 1'b0, sw = 1'b0, btn = 1'b0, rdy = 1'b0;
  logic [7:0] txd;
  logic txv;

  always #4 clk = ~clk;

  sw_activity_log #(.TICK_CYCLES(T), .DEPTH(D)) u_sw_activity_log (
    .clk(clk), .rst_n(rst_n), .sw_level(sw), .dump_btn(btn),
    .tx_data(txd), .tx_valid(txv), .tx_ready(rdy));

  int cyc, last_op, checks, fails;
  bit done;
  logic [7:0] model[$];
  logic [7:0] got[$];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic record_op();
    int e, g, iv;
    sw = ~sw;
    e = cyc + 1;
    g = e - last_op - 1;
    iv = g / T;
    if (iv > 127) iv = 127;
    model.push_back({sw, iv[6:0]});
    if (model.size() > D) void'(model.pop_front());
    last_op = e;
  endtask

  task automatic do_op(input int gap);
    repeat (gap) @(negedge clk);
    record_op();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sw = 1'b0; btn = 1'b0; rdy = 1'b0;
    model.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    last_op = 0;
  endtask

  // press, then act as the sink; mode 0 always ready, 1 ready every 3rd, 2 late
  task automatic collect(input int mode, input bit inject, input bit hold, input string req);
    logic [7:0] exp_q[$];
    int stall_bad;
    bit pv, pr, r;
    logic [7:0] pd;
    exp_q = model;
    got.delete();
    stall_bad = 0; pv = 0; pr = 0; pd = '0;
    btn = 1'b1;
    @(negedge clk);
    if (!hold) btn = 1'b0;
    for (int k = 0; k < 4 * D + 40; k++) begin
      if (pv && !pr && !(txv && txd == pd)) stall_bad++;
      if (inject) begin
        if (k == 2) record_op();
        if (k == 3) btn = 1'b1;
        if (k == 4) btn = 1'b0;
      end
      r = (mode == 0) ? 1'b1 : (mode == 1) ? (k % 3 == 2) : (k >= 6);
      rdy = r;
      if (txv && r) got.push_back(txd);
      pv = txv; pr = r; pd = txd;
      @(negedge clk);
    end
    rdy = 1'b0; btn = 1'b0;
    check(got.size() == exp_q.size(), {req, " byte count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++)
      if (i < got.size())
        check(got[i] == exp_q[i], {req, " R6 oldest-first order"}, got[i], exp_q[i]);
    check(stall_bad == 0, "R7 hold under backpressure", stall_bad, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int seen;
    // R11 reset state
    do_reset();
    @(negedge clk);
    check(txv == 1'b0, "R11 tx_valid low after reset", txv, 0);
    // R10 press with empty log
    btn = 1'b1; @(negedge clk); btn = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      if (txv) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R10 empty log press silent", seen, 0);

    // table walk: R1 R2 R3 R4
    do_reset();
    for (int i = 0; i < NV; i++) do_op(GAPS[i]);
    collect(0, 1'b0, 1'b0, "R1 R4 table dump");
    for (int i = 0; i < NV; i++)
      if (i < got.size())
        check(got[i] == EXPB[i], "R1 R2 R3 record byte", got[i], EXPB[i]);

    // R5 overflow of the log, dumped under backpressure
    for (int i = 0; i < 12; i++) do_op(7 * i + 3);
    collect(1, 1'b0, 1'b0, "R5 wrapped log");

    // R8 R9: press and switch change during an upload
    do_reset();
    do_op(20); do_op(40); do_op(60);
    collect(2, 1'b1, 1'b0, "R8 R9 in-flight");
    check(model.size() == 4, "R9 change during upload stored", model.size(), 4);
    collect(0, 1'b0, 1'b1, "R9 R8 next dump held button");

    finish_run();
  end
endmodule